// File: doc/BRIEF.md
# Fractional-N Feedback Divider Setting Calculator

This block turns a requested PLL ratio, given as a multiplier M and a divider N, into the settings that a fractional-N feedback divider consumes. These settings are a power-of-two pre-scale exponent P, the scaled divider N' = N·2^P, and the integer quotient Q and remainder R of N'/M. Using a reference frequency in kHz, it also computes the resulting VCO frequency. Every result is checked against its legal window. Each violated constraint raises its own flag, and an overall valid bit goes high only when no flag is set.

The work runs over many clock cycles. When the block is idle, a one-cycle start pulse captures M, N and the reference frequency. The block first finds floor(log2(N/M)) with one trial shift per cycle. It then runs a restoring shift-subtract division for N'/M, followed by a second one for fIN·N/M, each producing one quotient bit per cycle. A single-cycle done pulse marks the moment all outputs and flags have been updated. The results then hold until the next done pulse.

Top module: `pll_fracdiv_calc`

## Requirements
- R1: A synchronous active-high reset clears busy, done, valid, the flag bus and all numeric outputs to zero, including in the middle of a calculation.
- R2: A request with M = 0 or N = 0 sets flag bit 0. A request with N < M sets flag bit 1. Such a request finishes one clock edge after it is accepted, with P, N', Q, R and the VCO output all zero and flag bits 2 to 5 clear.
- R3: For a well-formed request, k = floor(log2(N/M)). P = 4 − k when k ≤ 4. When k > 4, flag bit 2 is set and P is clamped to 0.
- R4: N' equals N shifted left by P.
- R5: Q = floor(N'/M) and R = N' mod M. Flag bit 3 is set when Q lies outside 16..63. Flag bit 4 is set when R exceeds 511.
- R6: The VCO output equals floor(fIN·N/M) in kHz. Flag bit 5 is set when it lies outside 80000..230000.
- R7: After a done pulse, valid is high exactly when the flag bus is all zero.
- R8: For a well-formed request, done is high in the cycle after the (k+52)-th clock edge, counted from the edge that accepts start. Busy is high from the accepting edge until done, done lasts one cycle, and busy is low while done is high.
- R9: A start pulse that arrives while busy is high is ignored and does not change the result of the calculation in progress.
- R10: All result outputs and flags hold their values between done pulses.
- R11: At fIN = 27000 kHz, M=1 and N=4 give P=2, N'=16, Q=16, R=0 and a VCO of 108000. M=2 and N=11 give P=2, N'=44, Q=22, R=0 and a VCO of 148500. Both results are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| m_in | input | 9 | PLL multiplier M |
| n_in | input | 12 | PLL divider N |
| fin_khz | input | 20 | Reference frequency in kHz |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| p_out | output | 3 | Pre-scale exponent P |
| nprime_out | output | 16 | Scaled divider N' |
| q_out | output | 16 | Quotient Q of N'/M |
| r_out | output | 9 | Remainder R of N'/M |
| vco_khz | output | 32 | VCO frequency in kHz |
| err_flags | output | 6 | Bit 0 range, 1 order, 2 P, 3 Q, 4 R, 5 VCO |
| valid | output | 1 | No flag set in the latest result |

## Verification
The bound checker covers the protocol shape on every cycle. It checks that done is a single-cycle pulse that never coincides with busy, and that results stay frozen between pulses. It also checks that a valid result always carries P ≤ 4 and Q within its window, and that a malformed request leaves the numeric outputs zero. The actual arithmetic can only be shown by the bench scenarios, which compare every output each clock against an independent model. These include the exact latency that depends on k, the clamping of P, the VCO flag boundaries, start pulses ignored while busy, and a reset that arrives mid-calculation.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOG,
    ST_DIVQ,
    ST_DIVV
  } calc_state_t;

  localparam int FL_RANGE = 0;
  localparam int FL_ORDER = 1;
  localparam int FL_P     = 2;
  localparam int FL_Q     = 3;
  localparam int FL_R     = 4;
  localparam int FL_VCO   = 5;
  localparam int FL_W     = 6;

endpackage

// File: rtl/pll_calc_ilog2.sv
// Iterative floor(log2(n/m)): one trial doubling of m per cycle.
module pll_calc_ilog2 #(
  parameter int MW = 9,
  parameter int NW = 12,
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [MW-1:0] m_val,
  input  logic [NW-1:0] n_val,
  output logic [KW-1:0] k_out,
  output logic          fin
);

  localparam int SW = MW + NW;

  logic [SW-1:0] sh;
  logic [NW-1:0] nref;
  logic          active;
  logic [SW:0]   sh_next;
  logic          fits;

  always_comb begin
    sh_next = {sh, 1'b0};
    fits    = sh_next <= {{(MW + 1){1'b0}}, nref};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      nref   <= '0;
      active <= 1'b0;
      k_out  <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        sh     <= {{NW{1'b0}}, m_val};
        nref   <= n_val;
        k_out  <= '0;
        active <= 1'b1;
      end else if (active) begin
        if (fits) begin
          sh    <= sh_next[SW-1:0];
          k_out <= k_out + 1'b1;
        end else begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pll_calc_rdiv.sv
// Restoring shift-subtract divider, one quotient bit per cycle.
module pll_calc_rdiv #(
  parameter int DW = 16,
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quo,
  output logic [VW-1:0] rem,
  output logic          fin
);

  localparam int CW = $clog2(DW + 1);

  logic [VW-1:0] dvs;
  logic [CW-1:0] cnt;
  logic [VW:0]   rem_sh;
  logic          ge;

  always_comb begin
    rem_sh = {rem, quo[DW-1]};
    ge     = rem_sh >= {1'b0, dvs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo <= '0;
      rem <= '0;
      dvs <= '0;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        quo <= dividend;
        rem <= '0;
        dvs <= divisor;
        cnt <= CW'(DW);
      end else if (cnt != '0) begin
        quo <= {quo[DW-2:0], ge};
        rem <= ge ? VW'(rem_sh - {1'b0, dvs}) : VW'(rem_sh);
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) fin <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pll_fracdiv_calc.sv
module pll_fracdiv_calc
  import pll_calc_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 12,
  parameter int F_W         = 20,
  parameter int P_MAX       = 4,
  parameter int Q_MIN       = 16,
  parameter int Q_MAX       = 63,
  parameter int R_MAX       = 511,
  parameter int VCO_MIN_KHZ = 80000,
  parameter int VCO_MAX_KHZ = 230000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [M_W-1:0]             m_in,
  input  logic [N_W-1:0]             n_in,
  input  logic [F_W-1:0]             fin_khz,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(P_MAX+1)-1:0] p_out,
  output logic [N_W+P_MAX-1:0]       nprime_out,
  output logic [N_W+P_MAX-1:0]       q_out,
  output logic [M_W-1:0]             r_out,
  output logic [F_W+N_W-1:0]         vco_khz,
  output logic [5:0]                 err_flags,
  output logic                       valid
);

  localparam int P_W  = $clog2(P_MAX + 1);
  localparam int NP_W = N_W + P_MAX;
  localparam int K_W  = $clog2(N_W + 1);
  localparam int V_W  = F_W + N_W;
  localparam logic [NP_W-1:0] QLO  = NP_W'(Q_MIN);
  localparam logic [NP_W-1:0] QHI  = NP_W'(Q_MAX);
  localparam logic [V_W-1:0]  VLO  = V_W'(VCO_MIN_KHZ);
  localparam logic [V_W-1:0]  VHI  = V_W'(VCO_MAX_KHZ);

  calc_state_t     state;
  logic [M_W-1:0]  m_q;
  logic [N_W-1:0]  n_q;
  logic [F_W-1:0]  f_q;
  logic            rng_q, ord_q, perr_q;
  logic [P_W-1:0]  p_q;
  logic [NP_W-1:0] np_q, qq_q;
  logic [M_W-1:0]  rq_q;

  logic            rng_in, ord_in, log_load, log_fin;
  logic [K_W-1:0]  k_w;
  logic            perr_calc;
  logic [P_W-1:0]  p_calc;
  logic [NP_W-1:0] np_calc, q_quo;
  logic [M_W-1:0]  q_rem, v_rem;
  logic            q_fin, v_fin, divq_load, divv_load;
  logic [V_W-1:0]  v_dividend, v_quo;
  logic [FL_W-1:0] good_flags;

  always_comb begin
    rng_in     = (m_in == '0) || (n_in == '0);
    ord_in     = N_W'(m_in) > n_in;
    log_load   = (state == ST_IDLE) && start && !rng_in && !ord_in;
    perr_calc  = k_w > K_W'(P_MAX);
    p_calc     = perr_calc ? '0 : (P_W'(P_MAX) - P_W'(k_w));
    np_calc    = NP_W'(n_q) << p_calc;
    divq_load  = (state == ST_LOG) && log_fin && !rng_q && !ord_q;
    divv_load  = (state == ST_DIVQ) && q_fin;
    v_dividend = V_W'(f_q) * V_W'(n_q);
    good_flags           = '0;
    good_flags[FL_P]     = perr_q;
    good_flags[FL_Q]     = (qq_q < QLO) || (qq_q > QHI);
    good_flags[FL_R]     = int'(rq_q) > R_MAX;
    good_flags[FL_VCO]   = (v_quo < VLO) || (v_quo > VHI);
    busy       = state != ST_IDLE;
  end

  pll_calc_ilog2 #(.MW(M_W), .NW(N_W), .KW(K_W)) log_i (
    .clk(clk), .rst(rst), .load(log_load),
    .m_val(m_in), .n_val(n_in), .k_out(k_w), .fin(log_fin)
  );

  pll_calc_rdiv #(.DW(NP_W), .VW(M_W)) divq_i (
    .clk(clk), .rst(rst), .load(divq_load),
    .dividend(np_calc), .divisor(m_q),
    .quo(q_quo), .rem(q_rem), .fin(q_fin)
  );

  pll_calc_rdiv #(.DW(V_W), .VW(M_W)) divv_i (
    .clk(clk), .rst(rst), .load(divv_load),
    .dividend(v_dividend), .divisor(m_q),
    .quo(v_quo), .rem(v_rem), .fin(v_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      m_q        <= '0;
      n_q        <= '0;
      f_q        <= '0;
      rng_q      <= 1'b0;
      ord_q      <= 1'b0;
      perr_q     <= 1'b0;
      p_q        <= '0;
      np_q       <= '0;
      qq_q       <= '0;
      rq_q       <= '0;
      done       <= 1'b0;
      p_out      <= '0;
      nprime_out <= '0;
      q_out      <= '0;
      r_out      <= '0;
      vco_khz    <= '0;
      err_flags  <= '0;
      valid      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          m_q   <= m_in;
          n_q   <= n_in;
          f_q   <= fin_khz;
          rng_q <= rng_in;
          ord_q <= ord_in;
          state <= ST_LOG;
        end
        ST_LOG: begin
          if (rng_q || ord_q) begin
            p_out      <= '0;
            nprime_out <= '0;
            q_out      <= '0;
            r_out      <= '0;
            vco_khz    <= '0;
            err_flags  <= '0;
            err_flags[FL_RANGE] <= rng_q;
            err_flags[FL_ORDER] <= ord_q;
            valid      <= 1'b0;
            done       <= 1'b1;
            state      <= ST_IDLE;
          end else if (log_fin) begin
            p_q    <= p_calc;
            np_q   <= np_calc;
            perr_q <= perr_calc;
            state  <= ST_DIVQ;
          end
        end
        ST_DIVQ: if (q_fin) begin
          qq_q  <= q_quo;
          rq_q  <= q_rem;
          state <= ST_DIVV;
        end
        ST_DIVV: if (v_fin) begin
          p_out      <= p_q;
          nprime_out <= np_q;
          q_out      <= qq_q;
          r_out      <= rq_q;
          vco_khz    <= v_quo;
          err_flags  <= good_flags;
          valid      <= good_flags == '0;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Remainder of the VCO division is not part of the result.
  logic v_rem_unused;
  assign v_rem_unused = ^v_rem;

endmodule

// File: rtl/pll_fracdiv_calc_chk.sv
module pll_fracdiv_calc_chk #(
  parameter int M_W   = 9,
  parameter int N_W   = 12,
  parameter int F_W   = 20,
  parameter int P_MAX = 4,
  parameter int Q_MIN = 16,
  parameter int Q_MAX = 63
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       busy,
  input logic                       done,
  input logic [$clog2(P_MAX+1)-1:0] p_out,
  input logic [N_W+P_MAX-1:0]       nprime_out,
  input logic [N_W+P_MAX-1:0]       q_out,
  input logic [M_W-1:0]             r_out,
  input logic [F_W+N_W-1:0]         vco_khz,
  input logic [5:0]                 err_flags,
  input logic                       valid
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_valid_clean_R7: assert property (@(posedge clk) disable iff (rst)
    valid |-> (err_flags == 6'd0));

  assert_clean_is_valid_R7: assert property (@(posedge clk) disable iff (rst)
    (done && err_flags == 6'd0) |-> valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |->
      $stable({p_out, nprime_out, q_out, r_out, vco_khz, err_flags, valid}));

  assert_p_window_R3: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(p_out) <= P_MAX));

  assert_q_window_R5: assert property (@(posedge clk) disable iff (rst)
    valid |-> (int'(q_out) >= Q_MIN && int'(q_out) <= Q_MAX));

  assert_malformed_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (done && err_flags[1:0] != 2'b00) |->
      (q_out == '0 && vco_khz == '0 && p_out == '0 && err_flags[5:2] == 4'b0000));

endmodule

bind pll_fracdiv_calc pll_fracdiv_calc_chk #(
  .M_W(M_W), .N_W(N_W), .F_W(F_W), .P_MAX(P_MAX), .Q_MIN(Q_MIN), .Q_MAX(Q_MAX)
) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .p_out(p_out),
  .nprime_out(nprime_out), .q_out(q_out), .r_out(r_out), .vco_khz(vco_khz),
  .err_flags(err_flags), .valid(valid)
);

// File: tb/pll_fracdiv_calc_tb_top.sv
module pll_fracdiv_calc_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  m_in = '0;
  logic [11:0] n_in = '0;
  logic [19:0] fin_khz = '0;
  logic        busy, done, valid;
  logic [2:0]  p_out;
  logic [15:0] nprime_out, q_out;
  logic [8:0]  r_out;
  logic [31:0] vco_khz;
  logic [5:0]  err_flags;

  int n_cmp = 0;
  int n_bad = 0;
  bit armed = 1'b0;

  always #4 clk = ~clk;

  pll_fracdiv_calc dut_i (
    .clk(clk), .rst(rst), .start(start), .m_in(m_in), .n_in(n_in),
    .fin_khz(fin_khz), .busy(busy), .done(done), .p_out(p_out),
    .nprime_out(nprime_out), .q_out(q_out), .r_out(r_out),
    .vco_khz(vco_khz), .err_flags(err_flags), .valid(valid)
  );

  // Reference model state
  int     cd;
  bit     e_done, e_busy, e_valid;
  longint e_p, e_np, e_q, e_r, e_vco, e_flags;
  longint x_p, x_np, x_q, x_r, x_vco, x_flags;
  bit     x_valid;
  int     x_lat;

  function automatic void predict(longint m, longint n, longint f);
    int k;
    bit perr;
    if (m == 0 || n == 0 || n < m) begin
      x_flags = ((m == 0 || n == 0) ? 1 : 0) + ((n < m) ? 2 : 0);
      x_p = 0; x_np = 0; x_q = 0; x_r = 0; x_vco = 0;
      x_lat = 1;
    end else begin
      k = 0;
      while ((m << (k + 1)) <= n) k++;
      perr  = k > 4;
      x_p   = perr ? 0 : 4 - k;
      x_np  = n << x_p;
      x_q   = x_np / m;
      x_r   = x_np % m;
      x_vco = (f * n) / m;
      x_flags = (perr ? 4 : 0) + ((x_q < 16 || x_q > 63) ? 8 : 0)
              + ((x_r > 511) ? 16 : 0)
              + ((x_vco < 80000 || x_vco > 230000) ? 32 : 0);
      x_lat = k + 52;
    end
    x_valid = x_flags == 0;
  endfunction

  always @(posedge clk) begin
    armed = 1'b1;
    if (rst) begin
      cd = 0; e_done = 0; e_valid = 0;
      e_p = 0; e_np = 0; e_q = 0; e_r = 0; e_vco = 0; e_flags = 0;
    end else begin
      e_done = 0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          e_done = 1;
          e_p = x_p; e_np = x_np; e_q = x_q; e_r = x_r;
          e_vco = x_vco; e_flags = x_flags; e_valid = x_valid;
        end
      end else if (start) begin
        predict(longint'(m_in), longint'(n_in), longint'(fin_khz));
        cd = x_lat;
      end
    end
    e_busy = cd > 0;
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      check(rst ? "R1" : "R8", "busy", 64'(busy), 64'(e_busy));
      check(rst ? "R1" : "R8", "done", 64'(done), 64'(e_done));
      check(rst ? "R1" : "R3", "p", 64'(p_out), e_p);
      check(rst ? "R1" : "R4", "nprime", 64'(nprime_out), e_np);
      check(rst ? "R1" : "R5", "q", 64'(q_out), e_q);
      check(rst ? "R1" : "R5", "r", 64'(r_out), e_r);
      check(rst ? "R1" : "R6", "vco", 64'(vco_khz), e_vco);
      check(rst ? "R1" : "R2", "flags", 64'(err_flags), e_flags);
      check(rst ? "R1" : "R7", "valid", 64'(valid), 64'(e_valid));
    end
  end

  task automatic request(int m, int n, int f);
    @(negedge clk);
    m_in = 9'(m); n_in = 12'(n); fin_khz = 20'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 300; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic run(int m, int n, int f);
    request(m, n, f);
    wait_done();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired actual=busy expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared after reset
    check("R1", "done after reset", 64'(done), 64'd0);
    check("R1", "valid after reset", 64'(valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R11: worked examples
    run(1, 4, 27000);
    check("R11", "q ex1", 64'(q_out), 64'd16);
    check("R11", "vco ex1", 64'(vco_khz), 64'd108000);
    run(2, 11, 27000);
    check("R11", "nprime ex2", 64'(nprime_out), 64'd44);
    check("R11", "vco ex2", 64'(vco_khz), 64'd148500);
    check("R11", "valid ex2", 64'(valid), 64'd1);

    // R3 R5 R6: assorted well-formed ratios
    run(3, 10, 27000);      // k=1, R nonzero, valid
    run(1, 1, 27000);       // VCO below window (R6)
    run(1, 64, 27000);      // k=6: P clamped (R3), Q too big
    run(100, 4000, 5000);   // only the P flag
    run(1, 4095, 50);       // k=11 extreme
    run(511, 511, 100000);  // P=4, Q=16 boundary
    run(1, 5, 46000);       // VCO exactly 230000 edge
    run(1, 5, 46001);       // VCO just above window
    check("R6", "vco flag above", 64'(err_flags[5]), 64'd1);

    // R2: malformed requests
    run(0, 5, 27000);
    run(7, 3, 27000);
    check("R2", "order flag", 64'(err_flags), 64'd2);
    run(5, 0, 27000);

    // R9: start while busy ignored
    request(1, 4, 27000);
    repeat (5) @(negedge clk);
    m_in = 9'd7; n_in = 12'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R9", "q unaffected", 64'(q_out), 64'd16);
    repeat (2) @(negedge clk);

    // R10: results hold while idle
    repeat (6) @(negedge clk);
    check("R10", "q held", 64'(q_out), 64'd16);

    // R1: reset in mid-calculation
    request(3, 10, 27000);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", "busy after mid reset", 64'(busy), 64'd0);
    run(2, 11, 27000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule